// File: doc/BRIEF.md
# Timer-Triggered Multichannel ADC Scan Sequencer

This block drives an external analog-to-digital converter core through a single-cycle start pulse and a single-cycle done strobe carrying a 12-bit result. An internal periodic timer fires a trigger every programmed number of clock cycles. Each trigger launches one regular burst, which converts a programmed list of up to four channel numbers in list order. Every regular result leaves the block on a 16-bit valid/ready stream that feeds a DMA engine.

Software can also arm a one-shot injected group of one to four channels. The injected group waits until the regular burst in progress has fully drained, then converts its channels once. Its results land in dedicated readable result registers and never appear on the stream. A trigger that arrives while any conversion work is still running is dropped and recorded in a sticky overrun flag. The periodic timer keeps its own cadence regardless of injected work.

Stream rules: `dma_valid` rises when a regular result is ready and stays high, with `dma_data` unchanged, until a cycle in which `dma_ready` is high. The sequencer starts no further conversion while a result is waiting. Back-pressure therefore stretches the burst but never loses or reorders data.

Top module: `adcseq_top`

## Requirements
- R1: After reset, CTRL (address 0) reads 0, PERIOD (address 1) reads 2880, REGSEQ (address 2) and STATUS (address 4) read 0, and neither `cnv_start` nor `dma_valid` is asserted.
- R2: While CTRL bit 0 (enable) is set, regular bursts begin exactly PERIOD clock cycles apart when no trigger is dropped, and each conversion start is a single-cycle pulse.
- R3: REGSEQ holds channel slots of 5 bits at bits 4:0, 9:5, 14:10 and 19:15, and a count-minus-one field at bits 23:20. With scan enabled, a burst converts slots 0 through that count, in that order. Field values above 3 select all four slots.
- R4: With CTRL bit 1 (scan) clear, each burst converts only slot 0, whatever the count field holds.
- R5: Each regular result is presented once on `dma_data`, zero-extended from 12 to 16 bits and right-aligned. `dma_valid` and `dma_data` are held until `dma_ready`, and results leave in conversion order.
- R6: INJSEQ (address 3) uses the same 5-bit slot layout and holds its count-minus-one at bits 21:20. Writing CTRL with bit 2 set arms the group once. The group runs only after the current regular burst has finished. Its zero-extended results go to registers at addresses 5 to 8 and never to the stream.
- R7: STATUS bit 0 is set when the last injected result is stored, and is cleared by writing 1 to it.
- R8: A trigger arriving while a burst or injected group is active sets STATUS bit 1 and starts no burst. Later bursts still begin on multiples of PERIOD. Writing 1 to bit 1 clears it.
- R9: Clearing CTRL bit 0 stops all new bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cnv_start | output | 1 | One-cycle request to the converter |
| cnv_chan | output | 5 | Channel to convert, valid with `cnv_start` |
| cnv_done | input | 1 | One-cycle completion strobe from the converter |
| cnv_result | input | 12 | Conversion result, valid with `cnv_done` |
| dma_valid | output | 1 | Regular result available |
| dma_ready | input | 1 | Downstream accepts the result |
| dma_data | output | 16 | Zero-extended regular result |

## Verification
The hardest situation to create is an injected arm landing in the middle of a regular burst while the stream is being throttled. The group must then slot in after the burst's last accepted result, and it must not shift the next trigger. The stimulus waits for the first conversion start of a burst and issues the arm write at once, while a behavioural converter model and a cycle-by-cycle expectation of the channel order check where the injected starts fall. A short period relative to the burst length forces dropped triggers, and the bench then checks that burst spacing stays a multiple of the period.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD  = 4'd1;
  localparam logic [ADDR_W-1:0] A_REGSEQ  = 4'd2;
  localparam logic [ADDR_W-1:0] A_INJSEQ  = 4'd3;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'd4;
  localparam logic [ADDR_W-1:0] A_INJRES0 = 4'd5;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_SCAN = 1;
  localparam int CTRL_ARM  = 2;

  localparam int ST_INJDONE = 0;
  localparam int ST_OVR     = 1;
  localparam int ST_BUSY    = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REG_ISSUE,
    S_REG_WAIT,
    S_REG_PUSH,
    S_INJ_ISSUE,
    S_INJ_WAIT
  } seq_state_e;
endpackage

// File: rtl/adcseq_timer.sv
`timescale 1ns/1ps
module adcseq_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] limit;

  // A period of zero behaves like one: a trigger every cycle.
  assign limit = (period == '0) ? '0 : period - 1'b1;
  assign tick  = enable && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!enable || tick)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R2: with a period above one, triggers never come on consecutive cycles.
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (period > PERIOD_W'(1)) |=> !tick || (period != $past(period)));

  // R9: counting always restarts from zero when the timer is switched on.
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> (cnt_q == '0));
endmodule

// File: rtl/adcseq_regs.sv
`timescale 1ns/1ps
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int NREG         = 4,
  parameter int NINJ         = 4,
  parameter int CH_W         = 5,
  parameter int OUT_W        = 16,
  parameter int PERIOD_W     = 16,
  parameter int RESET_PERIOD = 2880,
  parameter int IDX_W        = 2,
  parameter int ILEN_W       = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       enable,
  output logic                       scan_en,
  output logic [PERIOD_W-1:0]        period,
  output logic [NREG-1:0][CH_W-1:0]  reg_chans,
  output logic [LEN_W-1:0]           reg_len,
  output logic [NINJ-1:0][CH_W-1:0]  inj_chans,
  output logic [ILEN_W-1:0]          inj_len,
  output logic                       arm,
  input  logic                       inj_wr,
  input  logic [IDX_W-1:0]           inj_wr_idx,
  input  logic [OUT_W-1:0]           inj_wr_data,
  input  logic                       inj_done_set,
  input  logic                       overrun_set,
  input  logic                       busy
);
  localparam int REGSEQ_W = NREG*CH_W + LEN_W;
  localparam int INJSEQ_W = NINJ*CH_W + ILEN_W;

  logic [1:0]                ctrl_q;
  logic [PERIOD_W-1:0]       period_q;
  logic [REGSEQ_W-1:0]       regseq_q;
  logic [INJSEQ_W-1:0]       injseq_q;
  logic                      injdone_q;
  logic                      ovr_q;
  logic [NINJ-1:0][OUT_W-1:0] inj_res_q;

  logic wr_ctrl, wr_period, wr_regseq, wr_injseq, wr_status;
  logic unused_wbits;

  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_period = wr_en && (addr == A_PERIOD);
  assign wr_regseq = wr_en && (addr == A_REGSEQ);
  assign wr_injseq = wr_en && (addr == A_INJSEQ);
  assign wr_status = wr_en && (addr == A_STATUS);
  assign unused_wbits = ^wdata[DATA_W-1:REGSEQ_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      period_q  <= PERIOD_W'(RESET_PERIOD);
      regseq_q  <= '0;
      injseq_q  <= '0;
      injdone_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= wdata[1:0];
      if (wr_period) period_q <= wdata[PERIOD_W-1:0];
      if (wr_regseq) regseq_q <= wdata[REGSEQ_W-1:0];
      if (wr_injseq) injseq_q <= wdata[INJSEQ_W-1:0];
      // Setting wins over a same-cycle write-one-to-clear.
      injdone_q <= inj_done_set | (injdone_q & ~(wr_status & wdata[ST_INJDONE]));
      ovr_q     <= overrun_set  | (ovr_q     & ~(wr_status & wdata[ST_OVR]));
    end
  end

  for (genvar g = 0; g < NINJ; g++) begin : g_injres
    always_ff @(posedge clk) begin
      if (!rst_n)                                          inj_res_q[g] <= '0;
      else if (inj_wr && (inj_wr_idx == IDX_W'(g)))        inj_res_q[g] <= inj_wr_data;
    end
  end

  assign enable    = ctrl_q[CTRL_EN];
  assign scan_en   = ctrl_q[CTRL_SCAN];
  assign period    = period_q;
  assign reg_chans = regseq_q[NREG*CH_W-1:0];
  assign reg_len   = regseq_q[NREG*CH_W +: LEN_W];
  assign inj_chans = injseq_q[NINJ*CH_W-1:0];
  assign inj_len   = injseq_q[NINJ*CH_W +: ILEN_W];
  assign arm       = wr_ctrl && wdata[CTRL_ARM];

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata = DATA_W'(ctrl_q);
      A_PERIOD: rdata = DATA_W'(period_q);
      A_REGSEQ: rdata = DATA_W'(regseq_q);
      A_INJSEQ: rdata = DATA_W'(injseq_q);
      A_STATUS: begin
        rdata[ST_INJDONE] = injdone_q;
        rdata[ST_OVR]     = ovr_q;
        rdata[ST_BUSY]    = busy;
      end
      default: begin
        for (int i = 0; i < NINJ; i++) begin
          if (addr == ADDR_W'(int'(A_INJRES0) + i)) rdata = DATA_W'(inj_res_q[i]);
        end
      end
    endcase
  end

  // R8: a dropped trigger is always remembered on the next cycle.
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_set |=> ovr_q);

  // R7: finishing the injected group raises the done flag.
  a_r7_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    inj_done_set |=> injdone_q);

  // R6: injected result registers change only on an injected write.
  a_r6_res_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_wr |=> $stable(inj_res_q));
endmodule

// File: rtl/adcseq_core.sv
`timescale 1ns/1ps
module adcseq_core
  import adcseq_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int NINJ   = 4,
  parameter int CH_W   = 5,
  parameter int RES_W  = 12,
  parameter int OUT_W  = 16,
  parameter int IDX_W  = 2,
  parameter int ILEN_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       scan_en,
  input  logic [NREG-1:0][CH_W-1:0]  reg_chans,
  input  logic [LEN_W-1:0]           reg_len,
  input  logic [NINJ-1:0][CH_W-1:0]  inj_chans,
  input  logic [ILEN_W-1:0]          inj_len,
  input  logic                       arm,
  output logic                       cnv_start,
  output logic [CH_W-1:0]            cnv_chan,
  input  logic                       cnv_done,
  input  logic [RES_W-1:0]           cnv_result,
  output logic                       dma_valid,
  input  logic                       dma_ready,
  output logic [OUT_W-1:0]           dma_data,
  output logic                       inj_wr,
  output logic [IDX_W-1:0]           inj_wr_idx,
  output logic [OUT_W-1:0]           inj_wr_data,
  output logic                       inj_done_set,
  output logic                       overrun_set,
  output logic                       busy
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic [RES_W-1:0] res_q;
  logic             pend_q;
  logic             launch;
  logic [IDX_W-1:0] reg_last, inj_last;
  logic             in_inj;

  // Last slot index of each group, clamped to the implemented slots.
  always_comb begin
    if (!scan_en)                              reg_last = '0;
    else if (reg_len >= LEN_W'(NREG-1))        reg_last = IDX_W'(NREG-1);
    else                                       reg_last = reg_len[IDX_W-1:0];
    if (inj_len >= ILEN_W'(NINJ-1))            inj_last = IDX_W'(NINJ-1);
    else                                       inj_last = IDX_W'(inj_len);
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    last_d  = last_q;
    launch  = 1'b0;
    case (state_q)
      S_IDLE: begin
        // The timer outranks a queued injected group so its cadence holds.
        if (tick) begin
          state_d = S_REG_ISSUE;
          idx_d   = '0;
          last_d  = reg_last;
        end else if (pend_q) begin
          state_d = S_INJ_ISSUE;
          idx_d   = '0;
          last_d  = inj_last;
          launch  = 1'b1;
        end
      end
      S_REG_ISSUE: state_d = S_REG_WAIT;
      S_REG_WAIT:  if (cnv_done) state_d = S_REG_PUSH;
      S_REG_PUSH: begin
        if (dma_ready) begin
          if (idx_q == last_q) begin
            if (pend_q) begin
              state_d = S_INJ_ISSUE;
              idx_d   = '0;
              last_d  = inj_last;
              launch  = 1'b1;
            end else begin
              state_d = S_IDLE;
            end
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = S_REG_ISSUE;
          end
        end
      end
      S_INJ_ISSUE: state_d = S_INJ_WAIT;
      S_INJ_WAIT: begin
        if (cnv_done) begin
          if (idx_q == last_q) state_d = S_IDLE;
          else begin
            idx_d   = idx_q + 1'b1;
            state_d = S_INJ_ISSUE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      res_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      if (state_q == S_REG_WAIT && cnv_done) res_q <= cnv_result;
      // A new arm during a running group queues one more run.
      pend_q  <= (pend_q & ~launch) | arm;
    end
  end

  assign in_inj       = (state_q == S_INJ_ISSUE) || (state_q == S_INJ_WAIT);
  assign cnv_start    = (state_q == S_REG_ISSUE) || (state_q == S_INJ_ISSUE);
  assign cnv_chan     = in_inj ? inj_chans[idx_q] : reg_chans[idx_q];
  assign dma_valid    = (state_q == S_REG_PUSH);
  assign dma_data     = OUT_W'(res_q);
  assign inj_wr       = (state_q == S_INJ_WAIT) && cnv_done;
  assign inj_wr_idx   = idx_q;
  assign inj_wr_data  = OUT_W'(cnv_result);
  assign inj_done_set = inj_wr && (idx_q == last_q);
  assign busy         = (state_q != S_IDLE);
  assign overrun_set  = tick && busy;

  // R5: a stalled result keeps both valid and data.
  a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && !dma_ready |=> dma_valid && $stable(dma_data));

  // R2: a conversion request lasts exactly one cycle.
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start);

  // R6: an injected result is never on the stream.
  a_r6_inj_not_dma: assert property (@(posedge clk) disable iff (!rst_n)
    inj_wr |-> !dma_valid);

  // R5: no new conversion is requested while a result waits.
  a_r5_no_start_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && !dma_ready |=> !cnv_start);
endmodule

// File: rtl/adcseq_top.sv
`timescale 1ns/1ps
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int NREG         = 4,
  parameter int NINJ         = 4,
  parameter int CH_W         = 5,
  parameter int RES_W        = 12,
  parameter int OUT_W        = 16,
  parameter int PERIOD_W     = 16,
  parameter int RESET_PERIOD = 2880
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                cnv_start,
  output logic [CH_W-1:0]     cnv_chan,
  input  logic                cnv_done,
  input  logic [RES_W-1:0]    cnv_result,
  output logic                dma_valid,
  input  logic                dma_ready,
  output logic [OUT_W-1:0]    dma_data
);
  localparam int NMAX   = (NREG > NINJ) ? NREG : NINJ;
  localparam int IDX_W  = $clog2(NMAX);
  localparam int ILEN_W = $clog2(NINJ);

  logic                      enable, scan_en, arm, tick;
  logic [PERIOD_W-1:0]       period;
  logic [NREG-1:0][CH_W-1:0] reg_chans;
  logic [LEN_W-1:0]          reg_len;
  logic [NINJ-1:0][CH_W-1:0] inj_chans;
  logic [ILEN_W-1:0]         inj_len;
  logic                      inj_wr, inj_done_set, overrun_set, busy;
  logic [IDX_W-1:0]          inj_wr_idx;
  logic [OUT_W-1:0]          inj_wr_data;

  adcseq_regs #(
    .NREG(NREG), .NINJ(NINJ), .CH_W(CH_W), .OUT_W(OUT_W), .PERIOD_W(PERIOD_W),
    .RESET_PERIOD(RESET_PERIOD), .IDX_W(IDX_W), .ILEN_W(ILEN_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .enable(enable), .scan_en(scan_en), .period(period),
    .reg_chans(reg_chans), .reg_len(reg_len), .inj_chans(inj_chans), .inj_len(inj_len),
    .arm(arm), .inj_wr(inj_wr), .inj_wr_idx(inj_wr_idx), .inj_wr_data(inj_wr_data),
    .inj_done_set(inj_done_set), .overrun_set(overrun_set), .busy(busy)
  );

  adcseq_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period(period), .tick(tick)
  );

  adcseq_core #(
    .NREG(NREG), .NINJ(NINJ), .CH_W(CH_W), .RES_W(RES_W), .OUT_W(OUT_W),
    .IDX_W(IDX_W), .ILEN_W(ILEN_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .scan_en(scan_en),
    .reg_chans(reg_chans), .reg_len(reg_len), .inj_chans(inj_chans), .inj_len(inj_len),
    .arm(arm), .cnv_start(cnv_start), .cnv_chan(cnv_chan), .cnv_done(cnv_done),
    .cnv_result(cnv_result), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_data(dma_data), .inj_wr(inj_wr), .inj_wr_idx(inj_wr_idx),
    .inj_wr_data(inj_wr_data), .inj_done_set(inj_done_set),
    .overrun_set(overrun_set), .busy(busy)
  );
endmodule

// File: tb/adcseq_top_tb.sv
`timescale 1ns/1ps
module adcseq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cnv_start;
  logic [4:0]  cnv_chan;
  logic        cnv_done = 1'b0;
  logic [11:0] cnv_result = '0;
  logic        dma_valid;
  logic        dma_ready = 1'b0;
  logic [15:0] dma_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnv_start(cnv_start),
    .cnv_chan(cnv_chan), .cnv_done(cnv_done), .cnv_result(cnv_result),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_data(dma_data)
  );

  int checks = 0, fails = 0;
  int cyc = 0, wd = 0;
  int reg_list[$];
  int inj_list[$];
  int exp_dma[$];
  int inj_exp[4];
  bit inj_expected = 0;
  int period = 1;
  bit strict = 0;
  int grp_kind = 0, grp_pos = 0;
  int last_burst = -1;
  int ready_mode = 0;
  bit conv_busy = 0;
  int conv_cnt = 0, conv_ch = 0, ser = 0;
  bit prev_stall = 0;
  logic [15:0] prev_data = '0;
  int start_cnt = 0, burst_cnt = 0, dma_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural converter and expectation model, evaluated once per clock.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cnv_done) cnv_done = 1'b0;
      if (conv_busy) begin
        conv_cnt--;
        if (conv_cnt == 0) begin
          int res;
          res = ((conv_ch & 31) << 7) | (ser & 127);
          ser++;
          cnv_result = 12'(res);
          cnv_done = 1'b1;
          conv_busy = 0;
          if (conv_ch < 16) exp_dma.push_back(res);
          else for (int i = 0; i < inj_list.size(); i++)
            if (inj_list[i] == conv_ch) inj_exp[i] = res;
        end
      end
      if (cnv_start) begin
        int c;
        c = int'(cnv_chan);
        start_cnt++;
        chk(!conv_busy, "R5", "start while converter busy", 1, 0);
        if (grp_kind == 1) begin
          chk(c == reg_list[grp_pos], "R3", "regular channel order", c, reg_list[grp_pos]);
          grp_pos++;
          if (grp_pos == reg_list.size()) grp_kind = 0;
        end else if (grp_kind == 2) begin
          chk(c == inj_list[grp_pos], "R6", "injected channel order", c, inj_list[grp_pos]);
          grp_pos++;
          if (grp_pos == inj_list.size()) begin grp_kind = 0; inj_expected = 0; end
        end else if (inj_expected && c == inj_list[0]) begin
          grp_kind = 2; grp_pos = 1;
          if (grp_pos == inj_list.size()) begin grp_kind = 0; inj_expected = 0; end
        end else begin
          chk(c == reg_list[0], "R3", "first channel of burst", c, reg_list[0]);
          burst_cnt++;
          if (last_burst >= 0) begin
            chk((cyc - last_burst) % period == 0, "R8", "burst spacing multiple of period",
                cyc - last_burst, period);
            if (strict) chk(cyc - last_burst == period, "R2", "burst spacing", cyc - last_burst, period);
          end
          last_burst = cyc;
          grp_kind = 1; grp_pos = 1;
          if (grp_pos == reg_list.size()) grp_kind = 0;
        end
        conv_busy = 1; conv_cnt = LAT; conv_ch = c;
      end
      dma_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (prev_stall)
        chk(dma_valid && dma_data == prev_data, "R5", "held result under back-pressure",
            dma_data, prev_data);
      prev_stall = 0;
      if (dma_valid && dma_ready) begin
        dma_cnt++;
        if (exp_dma.size() == 0) chk(0, "R5", "unexpected stream result", dma_data, -1);
        else begin
          int e;
          e = exp_dma.pop_front();
          chk(dma_data == 16'(e), "R5", "stream data", dma_data, e);
        end
      end else if (dma_valid) begin
        prev_stall = 1;
        prev_data = dma_data;
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > WATCHDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] pack4(input int c0, c1, c2, c3, len);
    return 32'((c0 & 31) | ((c1 & 31) << 5) | ((c2 & 31) << 10) | ((c3 & 31) << 15) | (len << 20));
  endfunction

  task automatic cfg(input int c0, c1, c2, c3, len, input bit scan, input int p, input bit st);
    wr(4'd0, 32'd0);
    repeat (60) @(negedge clk);
    chk(exp_dma.size() == 0, "R5", "stream drained", exp_dma.size(), 0);
    reg_list.delete();
    if (!scan) reg_list.push_back(c0);
    else begin
      int n;
      n = (len > 3) ? 4 : len + 1;
      if (n > 0) reg_list.push_back(c0);
      if (n > 1) reg_list.push_back(c1);
      if (n > 2) reg_list.push_back(c2);
      if (n > 3) reg_list.push_back(c3);
    end
    period = p; strict = st; last_burst = -1; grp_kind = 0;
    wr(4'd2, pack4(c0, c1, c2, c3, len));
    wr(4'd1, 32'(p));
    wr(4'd0, {30'd0, scan, 1'b1});
  endtask

  initial begin
    logic [31:0] d;
    int b0, s0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cnv_start == 1'b0 && dma_valid == 1'b0, "R1", "idle outputs", {cnv_start, dma_valid}, 0);
    rd(4'd0, d); chk(d == 0,    "R1", "CTRL reset",   d, 0);
    rd(4'd1, d); chk(d == 2880, "R1", "PERIOD reset", d, 2880);
    rd(4'd2, d); chk(d == 0,    "R1", "REGSEQ reset", d, 0);
    rd(4'd4, d); chk(d == 0,    "R1", "STATUS reset", d, 0);

    // R2 R3 R5: four-channel scan, stream always ready
    ready_mode = 0;
    cfg(3, 7, 1, 12, 3, 1'b1, 60, 1'b1);
    b0 = burst_cnt;
    repeat (400) @(negedge clk);
    chk(burst_cnt - b0 >= 6, "R2", "burst count", burst_cnt - b0, 6);
    rd(4'd4, d); chk(d[1] == 1'b0, "R8", "no overrun at slow rate", d[1], 0);

    // R5: two channels under back-pressure
    ready_mode = 1;
    cfg(5, 9, 0, 0, 1, 1'b1, 50, 1'b1);
    b0 = burst_cnt;
    repeat (300) @(negedge clk);
    chk(burst_cnt - b0 >= 5, "R5", "bursts under back-pressure", burst_cnt - b0, 5);

    // R3: count field above 3 selects all four slots
    cfg(2, 4, 6, 8, 9, 1'b1, 70, 1'b1);
    s0 = start_cnt; b0 = burst_cnt;
    repeat (300) @(negedge clk);
    chk(start_cnt - s0 == 4 * (burst_cnt - b0), "R3", "four starts per burst",
        start_cnt - s0, 4 * (burst_cnt - b0));

    // R4: scan off converts slot 0 only
    ready_mode = 0;
    cfg(11, 2, 3, 4, 3, 1'b0, 40, 1'b1);
    s0 = start_cnt; b0 = burst_cnt;
    repeat (200) @(negedge clk);
    chk(start_cnt - s0 == burst_cnt - b0 && burst_cnt - b0 >= 4, "R4", "one start per burst",
        start_cnt - s0, burst_cnt - b0);

    // R6 R7: injected group armed in the middle of a burst
    ready_mode = 1;
    inj_list.delete();
    inj_list.push_back(20); inj_list.push_back(21); inj_list.push_back(22);
    wr(4'd3, pack4(20, 21, 22, 0, 2));
    cfg(3, 7, 1, 12, 3, 1'b1, 80, 1'b1);
    wait (grp_kind == 1);
    inj_expected = 1;
    wr(4'd0, 32'h7);
    repeat (200) @(negedge clk);
    chk(inj_expected == 0, "R6", "injected group ran once", inj_expected, 0);
    for (int i = 0; i < 3; i++) begin
      rd(4'(5 + i), d);
      chk(d == 32'(inj_exp[i]), "R6", "injected result register", d, inj_exp[i]);
    end
    rd(4'd4, d); chk(d[0] == 1'b1, "R7", "injected done set", d[0], 1);
    wr(4'd4, 32'h1);
    rd(4'd4, d); chk(d[0] == 1'b0, "R7", "injected done cleared", d[0], 0);
    repeat (200) @(negedge clk);
    chk(inj_expected == 0 && grp_kind != 2, "R6", "no second injected run", grp_kind, 0);

    // R8: period shorter than a burst
    ready_mode = 0;
    cfg(1, 2, 3, 4, 3, 1'b1, 10, 1'b0);
    b0 = burst_cnt;
    repeat (200) @(negedge clk);
    rd(4'd4, d); chk(d[1] == 1'b1, "R8", "overrun flag set", d[1], 1);
    chk(burst_cnt - b0 < 20, "R8", "dropped triggers start nothing", burst_cnt - b0, 19);

    // R9: disable stops bursts; R8 flag clears by writing one
    wr(4'd0, 32'd0);
    repeat (60) @(negedge clk);
    wr(4'd4, 32'h2);
    rd(4'd4, d); chk(d[1] == 1'b0, "R8", "overrun flag cleared", d[1], 0);
    s0 = start_cnt;
    repeat (200) @(negedge clk);
    chk(start_cnt == s0, "R9", "no starts while disabled", start_cnt - s0, 0);
    chk(exp_dma.size() == 0, "R5", "all results delivered", exp_dma.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule